// File: doc/BRIEF.md
# Clock Generator Power-Down Sequencer

This block decides when the output clocks of a multi-output clock generator may run and when the crystal oscillator and the PLL VCO are powered. A power-down request arrives asynchronously and is active low. The block synchronizes it, and on entry it first forces every output clock group low. After a fixed number of hold cycles it removes the oscillator and VCO enables. On exit it powers the oscillator and VCO again. It then counts reference ticks through a stabilization window and only after that releases the output clocks.

The output groups are the processor clocks, the bus clocks and an auxiliary group that carries the reference, interrupt-controller and 48 MHz clocks. While running, the processor and bus groups follow their own stop inputs. In every other state those stop inputs have no effect. A new power-down request during the stabilization window sends the block straight back to the fully off state, and the output clocks stay low throughout.

The default `SETTLE_TICKS` of 2900 assumes a 1 µs tick, which keeps the whole wake time below 3 ms. Reset puts the block in the fully off state, so the first wake-up after reset follows the same path as any other exit.

Top module: `clkgen_pwrdn_seq`

## Requirements
- R1: While `rst_n` is low and on the first clock after it, all five enables (`cpu_clk_en`, `bus_clk_en`, `aux_clk_en`, `osc_en`, `vco_en`) are 0.
- R2: When `pwr_req_n` goes low in the running state, the three clock-group enables fall on the third rising edge that samples it low, and not earlier.
- R3: After the clock-group enables fall, `osc_en` and `vco_en` stay 1 for exactly `HOLD_CYCLES` cycles and then fall together. No clock-group enable is ever 1 while `osc_en` is 0.
- R4: In the fully off state all five enables are 0, and `ref_tick` pulses have no effect.
- R5: When `pwr_req_n` goes high in the off state (or after reset), `osc_en` and `vco_en` rise on the third rising edge that samples it high. The clock-group enables stay 0 until `SETTLE_TICKS` cycles with `ref_tick` = 1 have been sampled, and they rise on the edge that samples the last of those ticks.
- R6: The total wake time is 3 clock cycles plus `SETTLE_TICKS` tick periods.
- R7: If `pwr_req_n` is sampled low through the synchronizer during the stabilization window, the block returns to the off state. The clock-group enables never rise, and this holds even when the final tick arrives on the same edge. The tick count restarts from zero on the next exit.
- R8: While running, `cpu_clk_en` equals `cpu_stop_n` and `bus_clk_en` equals `bus_stop_n`, each delayed by two rising edges.
- R9: Outside the running state, `cpu_stop_n` and `bus_stop_n` have no effect on any enable.
- R10: While running, `aux_clk_en` is 1 whatever the stop inputs are.
- R11: A request released during the hold phase does not abort entry. The block still reaches the off state and only then starts a normal wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (internal processor-clock reference) |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_req_n | input | 1 | Asynchronous power-down request, active low |
| cpu_stop_n | input | 1 | Asynchronous processor-clock stop, active low |
| bus_stop_n | input | 1 | Asynchronous bus-clock stop, active low |
| ref_tick | input | 1 | One-cycle pulse from the stabilization time base |
| cpu_clk_en | output | 1 | Processor clock group enable |
| bus_clk_en | output | 1 | Bus clock group enable |
| aux_clk_en | output | 1 | Reference, interrupt-controller and 48 MHz group enable |
| osc_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | PLL VCO enable |

## Verification
A sequencer stuck in the wrong state shows at the ports within one cycle of the next event. Clock enables that stay high after the third edge of a request, or an oscillator enable that drops together with the clock enables, reveal a bad entry. A hold or settle counter that is off by one moves the `osc_en` fall, or the rise of the clock enables, by exactly one cycle or one tick. The bench samples those exact edges. An abort request that is ignored lets the clock enables rise at the end of the tick window, which the abort sweep checks at every tick position.

// File: rtl/pdseq_pkg.sv
// Shared types for the power-down sequencer.
package pdseq_pkg;
    // Sequencer states; the order of entry is RUN -> HOLD -> OFF, exit OFF -> WAKE -> RUN.
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HOLD = 2'd1,
        ST_OFF  = 2'd2,
        ST_WAKE = 2'd3
    } pdseq_state_e;
endpackage

// File: rtl/pdseq_sync.sv
// Two-stage synchronizer for a vector of asynchronous control inputs.
// Assumes each input is a level that stays stable for several clocks.
// RST_VAL gives the reset value of both stages per bit.
module pdseq_sync #(
    parameter int          WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic stage1;
            logic stage2;
            // Two flops per bit to resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage1 <= RST_VAL[b];
                    stage2 <= RST_VAL[b];
                end else begin
                    stage1 <= async_in[b];
                    stage2 <= stage1;
                end
            end
            assign sync_out[b] = stage2;
        end
    endgenerate
endmodule

// File: rtl/pdseq_counter.sv
// Event counter with synchronous clear; done pulses on the LIMIT-th counted event.
// Assumes LIMIT >= 1; the count wraps to zero when done fires.
module pdseq_counter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic done
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] count;

    // Terminal detect: this event is the last one of the window.
    assign done = inc && (count == CW'(LIMIT - 1));

    // Count qualifying events; clear outside the owning phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= done ? '0 : count + 1'b1;
        end
    end
endmodule

// File: rtl/pdseq_fsm.sv
// Power-down state machine. Moves RUN -> HOLD on a request, HOLD -> OFF after the
// hold window, OFF -> WAKE on release and WAKE -> RUN after the settle window.
// A request seen during WAKE takes priority and goes back to OFF.
// Assumes pd_req is already synchronized.
module pdseq_fsm
    import pdseq_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pd_req,
    input  logic         hold_done,
    input  logic         settle_done,
    output pdseq_state_e state
);
    pdseq_state_e state_nx;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  if (pd_req)           state_nx = ST_HOLD;
            ST_HOLD: if (hold_done)        state_nx = ST_OFF;
            ST_OFF:  if (!pd_req)          state_nx = ST_WAKE;
            ST_WAKE: if (pd_req)           state_nx = ST_OFF;
                     else if (settle_done) state_nx = ST_RUN;
            default:                       state_nx = ST_OFF;
        endcase
    end

    // State register; reset lands in the fully off state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end
endmodule

// File: rtl/clkgen_pwrdn_seq.sv
// Clock generator power-down sequencer (top).
// Synchronizes the request and stop inputs, runs the entry/exit state machine
// and decodes per-group clock enables plus oscillator and VCO enables.
// Assumes clk is the internal processor-clock reference and ref_tick is a
// single-cycle pulse from a slower time base (default: 1 us).
module clkgen_pwrdn_seq
    import pdseq_pkg::*;
#(
    parameter int HOLD_CYCLES  = 2,
    parameter int SETTLE_TICKS = 2900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_req_n,
    input  logic cpu_stop_n,
    input  logic bus_stop_n,
    input  logic ref_tick,
    output logic cpu_clk_en,
    output logic bus_clk_en,
    output logic aux_clk_en,
    output logic osc_en,
    output logic vco_en
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] sync_q;
    logic             pd_req;
    logic             cpu_run;
    logic             bus_run;
    logic             hold_done;
    logic             settle_done;
    pdseq_state_e     state;

    // Reset value 0 keeps the request asserted and the groups stopped until real inputs arrive.
    pdseq_sync #(
        .WIDTH   (NSYNC),
        .RST_VAL ('0)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({bus_stop_n, cpu_stop_n, pwr_req_n}),
        .sync_out (sync_q)
    );

    assign pd_req  = ~sync_q[0];
    assign cpu_run = sync_q[1];
    assign bus_run = sync_q[2];

    // Hold window: counts every cycle spent with outputs low and the oscillator still on.
    pdseq_counter #(
        .LIMIT (HOLD_CYCLES)
    ) u_hold_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != ST_HOLD),
        .inc   (state == ST_HOLD),
        .done  (hold_done)
    );

    // Settle window: counts reference ticks while the oscillator and VCO stabilize.
    pdseq_counter #(
        .LIMIT (SETTLE_TICKS)
    ) u_settle_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != ST_WAKE),
        .inc   (ref_tick && (state == ST_WAKE)),
        .done  (settle_done)
    );

    pdseq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pd_req      (pd_req),
        .hold_done   (hold_done),
        .settle_done (settle_done),
        .state       (state)
    );

    // Enable decode: stop inputs count only in RUN; the analog blocks stay on until OFF.
    always_comb begin
        cpu_clk_en = (state == ST_RUN) && cpu_run;
        bus_clk_en = (state == ST_RUN) && bus_run;
        aux_clk_en = (state == ST_RUN);
        osc_en     = (state != ST_OFF);
        vco_en     = (state != ST_OFF);
    end
endmodule

// File: rtl/pdseq_chk.sv
// Assertion checker for clkgen_pwrdn_seq, attached by bind.
// Watches only ports; keeps its own tick count for the settle window.
module pdseq_chk #(
    parameter int SETTLE_TICKS = 2900
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_req_n,
    input logic ref_tick,
    input logic cpu_clk_en,
    input logic bus_clk_en,
    input logic aux_clk_en,
    input logic osc_en,
    input logic vco_en
);
    int unsigned ticks_seen;

    // Count ticks while powered but not yet released; clear whenever power is off.
    always_ff @(posedge clk) begin
        if (!rst_n)                       ticks_seen <= 0;
        else if (!osc_en)                 ticks_seen <= 0;
        else if (!aux_clk_en && ref_tick) ticks_seen <= ticks_seen + 1;
    end

    // R1
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |=> !(cpu_clk_en || bus_clk_en || aux_clk_en || osc_en || vco_en));

    // R2
    entry_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(aux_clk_en) |-> !$past(pwr_req_n, 3));

    // R3
    clocks_need_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en || bus_clk_en || aux_clk_en) |-> (osc_en && vco_en));

    // R3
    osc_after_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en) |-> !$past(aux_clk_en));

    // R5
    settle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aux_clk_en) |-> (ticks_seen == SETTLE_TICKS) && $past(ref_tick));

    // R9
    stop_only_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en || bus_clk_en) |-> aux_clk_en);
endmodule

bind clkgen_pwrdn_seq pdseq_chk #(
    .SETTLE_TICKS (SETTLE_TICKS)
) u_pdseq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_req_n  (pwr_req_n),
    .ref_tick   (ref_tick),
    .cpu_clk_en (cpu_clk_en),
    .bus_clk_en (bus_clk_en),
    .aux_clk_en (aux_clk_en),
    .osc_en     (osc_en),
    .vco_en     (vco_en)
);

// File: tb/test_clkgen_pwrdn_seq.sv
// Self-checking bench: small hold/settle windows, sweeps over stop inputs and abort points.
module test_clkgen_pwrdn_seq;
    localparam int HOLD   = 2;
    localparam int SETTLE = 4;

    logic clk = 1'b0;
    logic rst_n, pwr_req_n, cpu_stop_n, bus_stop_n, ref_tick;
    logic cpu_clk_en, bus_clk_en, aux_clk_en, osc_en, vco_en;
    int   n_chk = 0;
    int   n_bad = 0;
    int   wd    = 0;

    always #4 clk = ~clk;

    clkgen_pwrdn_seq #(
        .HOLD_CYCLES  (HOLD),
        .SETTLE_TICKS (SETTLE)
    ) i_clkgen_pwrdn_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_req_n  (pwr_req_n),
        .cpu_stop_n (cpu_stop_n),
        .bus_stop_n (bus_stop_n),
        .ref_tick   (ref_tick),
        .cpu_clk_en (cpu_clk_en),
        .bus_clk_en (bus_clk_en),
        .aux_clk_en (aux_clk_en),
        .osc_en     (osc_en),
        .vco_en     (vco_en)
    );

    wire [4:0] outs = {cpu_clk_en, bus_clk_en, aux_clk_en, osc_en, vco_en};

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic chk(input logic [4:0] exp, input string tag);
        n_chk++;
        if (outs !== exp) begin
            n_bad++;
            $display("FAIL %s: {cpu,bus,aux,osc,vco} actual %b expected %b", tag, outs, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_once();
        ref_tick = 1'b1;
        cyc(1);
        ref_tick = 1'b0;
    endtask

    // From the start of WAKE: SETTLE-1 ticks keep clocks low, the last one releases them.
    task automatic wake_settle(input logic c, input logic b, input string tag);
        for (int i = 0; i < SETTLE - 1; i++) begin
            tick_once();
            chk(5'b00011, tag);
        end
        tick_once();
        chk({c, b, 3'b111}, tag);
    endtask

    // Called right after pwr_req_n was raised with the sequencer in OFF.
    task automatic wake_to_run(input logic c, input logic b, input string tag);
        cyc(2);
        chk(5'b00000, tag);
        cyc(1);
        chk(5'b00011, tag);
        wake_settle(c, b, tag);
    endtask

    // Watchdog: a hung run is a failed check and still reaches the summary.
    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        logic pc, pb;
        rst_n = 1'b0; pwr_req_n = 1'b1; cpu_stop_n = 1'b1; bus_stop_n = 1'b1; ref_tick = 1'b0;
        cyc(3);
        chk(5'b00000, "R1 in reset");
        rst_n = 1'b1;
        wake_to_run(1'b1, 1'b1, "R5 R6 wake after reset");

        // R8 R10: sweep stop inputs while running, check the two-edge latency.
        pc = 1'b1; pb = 1'b1;
        for (int s = 0; s < 4; s++) begin
            cpu_stop_n = s[0];
            bus_stop_n = s[1];
            cyc(1);
            chk({pc, pb, 3'b111}, "R8 stop not yet seen");
            cyc(1);
            chk({s[0], s[1], 3'b111}, "R8 R10 stop followed");
            pc = s[0]; pb = s[1];
        end
        tick_once();
        chk(5'b11111, "R10 tick ignored while running");

        // R2 R3: entry ordering and latency.
        pwr_req_n = 1'b0;
        cyc(2);
        chk(5'b11111, "R2 not before third edge");
        cyc(1);
        chk(5'b00011, "R2 clocks low on third edge");
        cyc(HOLD - 1);
        chk(5'b00011, "R3 oscillator held through hold window");
        cyc(1);
        chk(5'b00000, "R3 R4 oscillator off after hold");

        // R4 R9: stop inputs and ticks have no effect while off.
        for (int s = 0; s < 4; s++) begin
            cpu_stop_n = s[0];
            bus_stop_n = s[1];
            cyc(3);
            chk(5'b00000, "R9 stops ignored while off");
            tick_once();
            chk(5'b00000, "R4 tick ignored while off");
        end
        cpu_stop_n = 1'b1; bus_stop_n = 1'b1;

        // R7: abort the settle window after every possible number of ticks.
        for (int k = 0; k < SETTLE; k++) begin
            pwr_req_n = 1'b1;
            cyc(3);
            chk(5'b00011, "R7 waking before abort");
            for (int t = 0; t < k; t++) begin
                tick_once();
                chk(5'b00011, "R7 counting before abort");
            end
            pwr_req_n = 1'b0;
            cyc(2);
            chk(5'b00011, "R7 abort not yet seen");
            ref_tick = 1'b1;
            cyc(1);
            ref_tick = 1'b0;
            chk(5'b00000, "R7 abort wins over tick");
            cyc(2);
            chk(5'b00000, "R7 stays off");
        end
        pwr_req_n = 1'b1;
        wake_to_run(1'b1, 1'b1, "R7 R5 full count after abort");

        // R11: release during the hold window still completes entry.
        pwr_req_n = 1'b0;
        cyc(3);
        chk(5'b00011, "R11 in hold");
        pwr_req_n = 1'b1;
        cyc(1);
        chk(5'b00011, "R11 hold continues");
        cyc(1);
        chk(5'b00000, "R11 reaches off");
        cyc(1);
        chk(5'b00011, "R11 wakes after off");
        wake_settle(1'b1, 1'b1, "R11 R5 normal wake");

        // R9: wake with both groups stopped; only the aux group comes up.
        pwr_req_n = 1'b0;
        cyc(3 + HOLD);
        chk(5'b00000, "R3 off again");
        cpu_stop_n = 1'b0; bus_stop_n = 1'b0;
        pwr_req_n = 1'b1;
        wake_to_run(1'b0, 1'b0, "R9 R10 wake with groups stopped");

        rst_n = 1'b0;
        cyc(1);
        chk(5'b00000, "R1 reset while running");
        report();
    end
endmodule